// File: doc/BRIEF.md
# Dual-Channel Pixel Slice Concentrator

The block gathers 12-bit pixel slices from five upstream segment-finding sources and hands them to a downstream association stage over two 12-bit output channels. Each source writes its slices into small FIFOs. The first channel is served by sources 0, 1 and 2, and the second channel by sources 2, 3 and 4. Source 2 sits in the overlap and is written into one FIFO on each side.

A single controller starts a burst when the finders pulse `data_valid`. Both channels then emit 18 slices in the same cycles, one per clock, taking six slices from each of their three sources in turn. If `data_valid` arrives while a burst is still running, it is held in a one-deep queue. The next burst then follows without a gap, and a sticky flag records that an overlap occurred.

Top module: `pixel_concentrator`

## Requirements
- R1: After reset, `a_vld`, `b_vld` and `ovl_flag` are low, and `a_data` and `b_data` are zero. An output data bus is zero in every cycle where its valid is low.
- R2: When `data_valid` is sampled high at a clock edge while no burst is active, the first slice appears with its valid high after the second following edge, which is two cycles of latency.
- R3: A burst drives `a_vld` and `b_vld` high together for exactly 18 consecutive cycles.
- R4: Source s occupies bits [12s+11:12s] of `src_data` and is written when bit s of `src_wr` is high. Channel A sends six slices of source 0, then six of source 1, then six of source 2. Channel B sends six slices of source 2, then six of source 3, then six of source 4.
- R5: The slices of each source leave in the order they were written. Every slice of source 2 appears on both channels.
- R6: Writing slices without `data_valid` starts no burst, and both valids stay low.
- R7: A `data_valid` sampled while a burst is active, including on its last cycle, starts a second burst. That burst begins in the cycle right after the last slice of the current one.
- R8: `ovl_flag` rises after a `data_valid` that is sampled during an active burst. It then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_data | input | 60 | Five packed 12-bit source slices |
| src_wr | input | 5 | Per-source write strobe |
| data_valid | input | 1 | Finder data-valid, starts a burst |
| a_data | output | 12 | Channel A slice |
| a_vld | output | 1 | Channel A slice valid |
| b_data | output | 12 | Channel B slice |
| b_vld | output | 1 | Channel B slice valid |
| ovl_flag | output | 1 | Sticky overlap flag |

## Verification
The assertions assume that `data_valid` is a pulse, and that every FIFO already holds the six slices a burst takes before that burst starts. They also assume that no more than two bursts' worth of slices are waiting at any time. The stimulus meets these assumptions. It writes six random slices, or twelve when a second burst is queued, into all five sources in parallel before it pulses `data_valid`. It places at most one extra pulse inside a running burst, at a random cycle or in fixed corner cycles such as the first and the last. Under these conditions the FIFOs neither underflow nor overflow.

// File: rtl/pixel_concentrator.sv
module pixel_concentrator #(
  parameter int W     = 12,
  parameter int NSRC  = 5,
  parameter int SPS   = 6,
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC*W-1:0] src_data,
  input  logic [NSRC-1:0]   src_wr,
  input  logic              data_valid,
  output logic [W-1:0]      a_data,
  output logic              a_vld,
  output logic [W-1:0]      b_data,
  output logic              b_vld,
  output logic              ovl_flag
);
  localparam int PER   = 3;
  localparam int BURST = PER * SPS;
  localparam int CW    = $clog2(BURST);
  localparam int SW    = $clog2(PER);
  localparam int AW    = $clog2(DEPTH);

  logic          busy_q, pend_q;
  logic [CW-1:0] cnt_q;
  logic [SW-1:0] sel;
  logic          last;
  logic [W-1:0]  head [2][PER];

  assign sel  = SW'(cnt_q / CW'(SPS));
  assign last = (cnt_q == CW'(BURST - 1));

  for (genvar c = 0; c < 2; c++) begin : g_ch
    for (genvar j = 0; j < PER; j++) begin : g_fifo
      localparam int S = 2 * c + j;
      logic [W-1:0]  mem [DEPTH];
      logic [AW-1:0] wp, rp;
      logic [AW:0]   fill;
      logic          push, pop;

      assign push = src_wr[S] && (fill != (AW+1)'(DEPTH));
      assign pop  = busy_q && (sel == SW'(j)) && (fill != '0);
      assign head[c][j] = (fill != '0) ? mem[rp] : '0;

      always_ff @(posedge clk) begin
        if (push) mem[wp] <= src_data[S*W +: W];
      end

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          wp   <= '0;
          rp   <= '0;
          fill <= '0;
        end else begin
          if (push) wp <= wp + 1'b1;
          if (pop)  rp <= rp + 1'b1;
          fill <= fill + (AW+1)'(push) - (AW+1)'(pop);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      pend_q   <= 1'b0;
      cnt_q    <= '0;
      ovl_flag <= 1'b0;
    end else if (!busy_q) begin
      if (data_valid) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end else begin
      if (data_valid) ovl_flag <= 1'b1;
      if (last) begin
        cnt_q  <= '0;
        busy_q <= pend_q || data_valid;
        pend_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        if (data_valid) pend_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_vld  <= 1'b0;
      b_vld  <= 1'b0;
      a_data <= '0;
      b_data <= '0;
    end else begin
      a_vld  <= busy_q;
      b_vld  <= busy_q;
      a_data <= busy_q ? head[0][sel] : '0;
      b_data <= busy_q ? head[1][sel] : '0;
    end
  end
endmodule

module pixel_concentrator_chk #(
  parameter int W     = 12,
  parameter int BURST = 18
) (
  input logic         clk,
  input logic         rst_n,
  input logic         data_valid,
  input logic         busy,
  input logic         a_vld,
  input logic         b_vld,
  input logic [W-1:0] a_data,
  input logic [W-1:0] b_data,
  input logic         ovl_flag
);
  localparam int RW = $clog2(BURST);
  logic [RW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= '0;
    else if (a_vld) run_q <= (run_q == RW'(BURST - 1)) ? '0 : run_q + 1'b1;
    else run_q <= '0;
  end

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !a_vld |-> (a_data == '0) && (b_data == '0)); // R1
  AST_START_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && !busy) |-> ##2 a_vld); // R2
  AST_LOCKSTEP: assert property (@(posedge clk) disable iff (!rst_n)
    a_vld == b_vld); // R3
  AST_BURST_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(a_vld) |-> (run_q == '0)); // R3
  AST_OVL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && busy) |=> ovl_flag); // R8
  AST_OVL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovl_flag |=> ovl_flag); // R8
endmodule

bind pixel_concentrator pixel_concentrator_chk #(.W(W), .BURST(BURST)) u_chk (
  .clk(clk), .rst_n(rst_n), .data_valid(data_valid), .busy(busy_q),
  .a_vld(a_vld), .b_vld(b_vld), .a_data(a_data), .b_data(b_data),
  .ovl_flag(ovl_flag)
);

// File: tb/pixel_concentrator_tb.sv
module pixel_concentrator_tb;
  localparam int W = 12;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [59:0]   src_data = '0;
  logic [4:0]    src_wr = '0;
  logic          data_valid = 1'b0;
  logic [W-1:0]  a_data, b_data;
  logic          a_vld, b_vld, ovl_flag;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [W-1:0] exp_s [5][12];
  logic         rva [64], rvb [64];
  logic [W-1:0] rda [64], rdb [64];

  always #4 clk = ~clk;

  pixel_concentrator u_dut (
    .clk(clk), .rst_n(rst_n), .src_data(src_data), .src_wr(src_wr),
    .data_valid(data_valid), .a_data(a_data), .a_vld(a_vld),
    .b_data(b_data), .b_vld(b_vld), .ovl_flag(ovl_flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_slice(input int ch, input int i);
    int b = i / 18;
    int r = i % 18;
    return exp_s[2*ch + r/6][b*6 + r%6];
  endfunction

  task automatic fill(input int nb);
    for (int i = 0; i < 6*nb; i++) begin
      @(negedge clk);
      chk(!a_vld && !b_vld, "R6 no burst without data_valid", a_vld, 0);
      src_wr = 5'h1f;
      for (int s = 0; s < 5; s++) begin
        exp_s[s][i] = W'($urandom);
        src_data[s*W +: W] = exp_s[s][i];
      end
    end
    @(negedge clk);
    src_wr = '0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!a_vld && !b_vld, "R6 idle after writes", a_vld, 0);
    end
  endtask

  task automatic run(input int nb, input int dv2_at);
    data_valid = 1'b1;
    for (int j = 0; j < 18*nb + 3; j++) begin
      @(negedge clk);
      rva[j] = a_vld; rvb[j] = b_vld; rda[j] = a_data; rdb[j] = b_data;
      data_valid = (j == dv2_at);
    end
    data_valid = 1'b0;
    chk(!rva[0], "R2 no valid one cycle after start", rva[0], 0);
    chk(rva[1], "R2 valid two cycles after start", rva[1], 1);
    for (int j = 1; j < 18*nb + 3; j++) begin
      bit ev = (j <= 18*nb);
      chk(rva[j] == ev && rvb[j] == ev, nb > 1 ? "R7 gapless queued burst" : "R3 18-cycle burst",
          {rva[j], rvb[j]}, {ev, ev});
      if (ev) begin
        chk(rda[j] == exp_slice(0, j-1), "R4 R5 channel A slice", rda[j], exp_slice(0, j-1));
        chk(rdb[j] == exp_slice(1, j-1), "R4 R5 channel B slice", rdb[j], exp_slice(1, j-1));
      end else begin
        chk(rda[j] == '0 && rdb[j] == '0, "R1 zero data when idle", rda[j], 0);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(!a_vld && !b_vld && !ovl_flag && a_data == '0 && b_data == '0,
        "R1 reset state", {a_vld, b_vld, ovl_flag}, 0);
    rst_n = 1'b1;
    for (int t = 0; t < 6; t++) begin
      fill(1);
      run(1, -1);
      chk(!ovl_flag, "R8 no overlap on isolated burst", ovl_flag, 0);
    end
    fill(2);
    run(2, 17);
    chk(ovl_flag, "R8 flag after dv on last cycle", ovl_flag, 1);
    fill(2);
    run(2, 0);
    for (int t = 0; t < 6; t++) begin
      fill(2);
      run(2, int'($urandom_range(0, 17)));
      chk(ovl_flag, "R8 flag sticky", ovl_flag, 1);
    end
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!ovl_flag && !a_vld, "R8 R1 reset clears flag", ovl_flag, 0);
    rst_n = 1'b1;
    fill(1);
    run(1, -1);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule